// File: doc/BRIEF.md
# Fully Associative Translation Cache with Access-Rights Check

This block translates a 32-bit virtual address into a physical address by looking up a small, fully associative cache of page mappings. Pages are 4 KB in size. The upper twenty address bits name the virtual page. Each cached entry holds a validity flag, the virtual page tag, the physical page number and three access-rights flags: read allowed, write allowed and user accessible. A lookup is purely combinational. In the same cycle it reports a hit with a usable physical address, a miss that asks an external table walker for the mapping, or a protection fault when the mapping exists but the requested access is not permitted.

The walker installs a complete entry through the refill port, and the write lands on the next clock edge. If the page is already cached, the refill overwrites that entry. Otherwise the lowest-numbered empty slot is used. When every slot is occupied, a round-robin pointer chooses the slot to evict. A flush input empties the whole cache in one cycle, which is needed when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, lk_paddr equals {stored physical page number, lk_vaddr[11:0]}. The low 12 offset bits pass through unchanged.
- R2: A lookup matches only an entry that is valid and whose tag equals lk_vaddr[31:12]. With no such entry the lookup raises lk_miss.
- R3: Permission rule: a read (lk_write=0) needs the entry's read flag, and a write (lk_write=1) needs its write flag. A user-mode request (lk_user=1) also needs the user flag. Kernel mode (lk_user=0) ignores the user flag.
- R4: A matching lookup that breaks the permission rule raises lk_fault, keeps lk_hit low and drives lk_paddr to zero.
- R5: While lk_valid is high, exactly one of lk_hit, lk_miss and lk_fault is high. While lk_valid is low, all three are low, and lk_paddr is zero whenever lk_hit is low.
- R6: A refill presented with fill_valid is written on the next rising clock edge and can be hit in the following cycle.
- R7: A refill whose page number is already cached overwrites that entry and consumes no other slot.
- R8: A refill of a new page uses the lowest-numbered invalid slot when one exists, so a run of new pages into a cache with free slots evicts nothing.
- R9: When all slots are valid, a refill of a new page replaces the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one after each such replacement.
- R10: A flush invalidates every entry at one clock edge, and a refill presented in the same cycle as flush is discarded.
- R11: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request active |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_hit | output | 1 | Translation usable |
| lk_miss | output | 1 | No matching entry; walk needed |
| lk_fault | output | 1 | Matching entry forbids this access |
| lk_paddr | output | 32 | Physical address (zero unless hit) |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Installed read permission |
| fill_wr | input | 1 | Installed write permission |
| fill_usr | input | 1 | Installed user-access permission |

## Verification
The lookup outputs are combinational, so the result for a request is due in the same cycle the request is driven. The bench drives each request just after a rising edge, and its monitor compares the queued expectation at the following falling edge. A refill changes nothing until the edge that ends its cycle. For that reason the bench only ever looks up a refilled page in a later cycle, and the same holds for the cycle after a flush. Eviction order is observed purely at the ports, by checking which previously installed pages begin to miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // access-rights flags kept with each cached mapping
   typedef struct packed {
      logic rd;
      logic wr;
      logic usr;
   } tlb_rights_t;

endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
   import tlb_pkg::*;
(
   input  tlb_rights_t rights,
   input  logic        req_write,
   input  logic        req_user,
   output logic        allow
);

   logic kind_ok;
   logic mode_ok;

   always_comb begin
      kind_ok = req_write ? rights.wr : rights.rd;
      mode_ok = !req_user || rights.usr;
      allow   = kind_ok && mode_ok;
   end

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  tlb_rights_t        wr_rights,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [VPN_W-1:0]   probe_vpn,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] probe_match,
   output logic [PPN_W-1:0]   lk_ppn,
   output tlb_rights_t        lk_rights
);

   logic [VPN_W-1:0] tag_q    [ENTRIES];
   logic [PPN_W-1:0] ppn_q    [ENTRIES];
   tlb_rights_t      rights_q [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)     valid_vec[g] <= 1'b0;
         else if (flush) valid_vec[g] <= 1'b0;
         else if (sel)   valid_vec[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q[g]    <= wr_vpn;
            ppn_q[g]    <= wr_ppn;
            rights_q[g] <= wr_rights;
         end
      end

      assign lk_match[g]    = valid_vec[g] && (tag_q[g] == lk_vpn);
      assign probe_match[g] = valid_vec[g] && (tag_q[g] == probe_vpn);
   end

   // at most one entry matches, so an OR of gated fields selects it
   always_comb begin
      lk_ppn    = '0;
      lk_rights = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) begin
            lk_ppn    = lk_ppn | ppn_q[i];
            lk_rights = lk_rights | rights_q[i];
         end
      end
   end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] probe_match,
   output logic [IDX_W-1:0]   victim
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] same_idx;
   logic [IDX_W-1:0] free_idx;
   logic             use_ptr;

   always_comb begin
      same_idx = '0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (probe_match[i]) same_idx = IDX_W'(i);
         if (!valid_vec[i])  free_idx = IDX_W'(i);
      end
      use_ptr = 1'b0;
      if (|probe_match)      victim = same_idx;
      else if (!(&valid_vec)) victim = free_idx;
      else begin
         victim  = ptr_q;
         use_ptr = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else if (fill_go && use_ptr) begin
         if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_q <= '0;
         else                              ptr_q <= ptr_q + 1'b1;
      end
   end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PPN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             lk_user,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic             lk_fault,
   output logic [PA_W-1:0]  lk_paddr,
   input  logic             fill_valid,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             fill_usr
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_xlate: ENTRIES must be at least 2");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("tlb_xlate: PAGE_BITS must be below both address widths");
   end

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] probe_match;
   logic [PPN_W-1:0]   hit_ppn;
   tlb_rights_t        hit_rights;
   tlb_rights_t        fill_rights;
   logic [IDX_W-1:0]   victim;
   logic               fill_go;
   logic               any_match;
   logic               allow;

   assign fill_go     = fill_valid && !flush;
   assign fill_rights = '{rd: fill_rd, wr: fill_wr, usr: fill_usr};

   tlb_entry_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) i_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .wr_en       (fill_go),
      .wr_idx      (victim),
      .wr_vpn      (fill_vpn),
      .wr_ppn      (fill_ppn),
      .wr_rights   (fill_rights),
      .lk_vpn      (lk_vaddr[VA_W-1:PAGE_BITS]),
      .probe_vpn   (fill_vpn),
      .valid_vec   (valid_vec),
      .lk_match    (lk_match),
      .probe_match (probe_match),
      .lk_ppn      (hit_ppn),
      .lk_rights   (hit_rights)
   );

   tlb_victim #(
      .ENTRIES (ENTRIES)
   ) i_victim (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_go     (fill_go),
      .valid_vec   (valid_vec),
      .probe_match (probe_match),
      .victim      (victim)
   );

   tlb_perm i_perm (
      .rights    (hit_rights),
      .req_write (lk_write),
      .req_user  (lk_user),
      .allow     (allow)
   );

   assign any_match = |lk_match;

   always_comb begin
      lk_miss  = lk_valid && !any_match;
      lk_fault = lk_valid && any_match && !allow;
      lk_hit   = lk_valid && any_match && allow;
      lk_paddr = lk_hit ? {hit_ppn, lk_vaddr[PAGE_BITS-1:0]} : '0;
   end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      flush,
   input logic                      lk_valid,
   input logic [VA_W-1:0]           lk_vaddr,
   input logic                      lk_hit,
   input logic                      lk_miss,
   input logic                      lk_fault,
   input logic [PA_W-1:0]           lk_paddr,
   input logic                      fill_valid,
   input logic [VA_W-PAGE_BITS-1:0] fill_vpn
);

   p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit && !lk_miss && !lk_fault);

   p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

   p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> lk_paddr == '0);

   p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lk_hit && !lk_fault);

   p_fill_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && !flush) ##1
      (lk_valid && lk_vaddr[VA_W-1:PAGE_BITS] == $past(fill_vpn)) |-> !lk_miss);

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .VA_W      (VA_W),
   .PA_W      (PA_W),
   .PAGE_BITS (PAGE_BITS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .lk_valid   (lk_valid),
   .lk_vaddr   (lk_vaddr),
   .lk_hit     (lk_hit),
   .lk_miss    (lk_miss),
   .lk_fault   (lk_fault),
   .lk_paddr   (lk_paddr),
   .fill_valid (fill_valid),
   .fill_vpn   (fill_vpn)
);

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_write = 1'b0;
   logic        lk_user = 1'b0;
   logic        lk_hit, lk_miss, lk_fault;
   logic [31:0] lk_paddr;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_usr = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic        hit;
      logic        miss;
      logic        fault;
      logic [31:0] paddr;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   tlb_xlate i_tlb_xlate (
      .clk (clk), .rst_n (rst_n), .flush (flush),
      .lk_valid (lk_valid), .lk_vaddr (lk_vaddr), .lk_write (lk_write), .lk_user (lk_user),
      .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_fault (lk_fault), .lk_paddr (lk_paddr),
      .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_ppn (fill_ppn),
      .fill_rd (fill_rd), .fill_wr (fill_wr), .fill_usr (fill_usr)
   );

   // monitor: compares each queued expectation at the falling edge after it was driven
   initial begin
      forever begin
         @(negedge clk);
         #0.5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (lk_hit !== e.hit || lk_miss !== e.miss || lk_fault !== e.fault ||
                lk_paddr !== e.paddr) begin
               failures++;
               $display("FAIL %s: got hit=%b miss=%b fault=%b paddr=%h, expected hit=%b miss=%b fault=%b paddr=%h",
                        e.tag, lk_hit, lk_miss, lk_fault, lk_paddr,
                        e.hit, e.miss, e.fault, e.paddr);
            end
         end
      end
   end

   task automatic quiet_inputs();
      flush = 1'b0; fill_valid = 1'b0; lk_valid = 1'b0;
   endtask

   // result outcome: 0 hit, 1 miss, 2 fault
   task automatic look(input logic [31:0] va, input logic wr, input logic usr,
                       input int outcome, input logic [19:0] ppn, input string tag);
      exp_t e;
      @(posedge clk); #1;
      quiet_inputs();
      lk_valid = 1'b1; lk_vaddr = va; lk_write = wr; lk_user = usr;
      e.hit   = (outcome == 0);
      e.miss  = (outcome == 1);
      e.fault = (outcome == 2);
      e.paddr = (outcome == 0) ? {ppn, va[11:0]} : 32'h0;
      e.tag   = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input logic [31:0] va, input string tag);
      exp_t e;
      @(posedge clk); #1;
      quiet_inputs();
      lk_vaddr = va;
      e.hit = 1'b0; e.miss = 1'b0; e.fault = 1'b0; e.paddr = 32'h0; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic r, input logic w, input logic u, input logic with_flush);
      @(posedge clk); #1;
      quiet_inputs();
      fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
      fill_rd = r; fill_wr = w; fill_usr = u;
      flush = with_flush;
   endtask

   task automatic do_flush();
      @(posedge clk); #1;
      quiet_inputs();
      flush = 1'b1;
   endtask

   initial begin
      #200000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 / R5: reset state
      idle(32'h12345ABC, "R5 idle after reset");
      look(32'h12345ABC, 1'b0, 1'b0, 1, 20'h0, "R11 empty after reset misses");

      // A: kernel read-only, U: user read-write, C: user write-only
      fill(20'h12345, 20'h00A11, 1'b1, 1'b0, 1'b0, 1'b0);
      fill(20'h00010, 20'h00B22, 1'b1, 1'b1, 1'b1, 1'b0);
      fill(20'h7FFFF, 20'hFFFFF, 1'b0, 1'b1, 1'b1, 1'b0);

      look(32'h12345ABC, 1'b0, 1'b0, 0, 20'h00A11, "R1 R6 kernel read hit");
      look(32'h12345ABC, 1'b1, 1'b0, 2, 20'h0,     "R3 R4 write to read-only faults");
      look(32'h12345000, 1'b0, 1'b1, 2, 20'h0,     "R3 R4 user read of kernel page faults");
      look(32'h00010FFF, 1'b1, 1'b1, 0, 20'h00B22, "R1 R3 user write hit");
      look(32'h00010000, 1'b0, 1'b0, 0, 20'h00B22, "R3 kernel reads user page");
      look(32'h7FFFF123, 1'b0, 1'b1, 2, 20'h0,     "R3 read without read flag faults");
      look(32'h7FFFF123, 1'b1, 1'b1, 0, 20'hFFFFF, "R1 write-only page write hit");
      look(32'h12346ABC, 1'b0, 1'b0, 1, 20'h0,     "R2 neighbouring page misses");

      // R7: refill of cached page overwrites it
      fill(20'h12345, 20'h00A99, 1'b1, 1'b1, 1'b0, 1'b0);
      look(32'h12345004, 1'b1, 1'b0, 0, 20'h00A99, "R7 overwritten entry used");

      // R8: remaining five free slots take new pages without eviction
      for (int i = 0; i < 5; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 5; i++) look({20'h00100 + 20'(i), 12'h010}, 1'b0, 1'b1, 0, 20'h00200 + 20'(i), "R8 free slot fill");
      look(32'h00010010, 1'b0, 1'b1, 0, 20'h00B22, "R7 R8 earlier page still cached");

      // R9: cache full, round-robin evicts slot 0 then slot 1
      fill(20'h0AAAA, 20'h0BBBB, 1'b1, 1'b1, 1'b1, 1'b0);
      look(32'h12345004, 1'b0, 1'b0, 1, 20'h0,     "R9 slot 0 evicted first");
      look(32'h0AAAA777, 1'b0, 1'b1, 0, 20'h0BBBB, "R9 new page hit");
      fill(20'h0CCCC, 20'h0DDDD, 1'b1, 1'b1, 1'b1, 1'b0);
      look(32'h00010010, 1'b0, 1'b1, 1, 20'h0,     "R9 slot 1 evicted second");
      look(32'h7FFFF456, 1'b1, 1'b1, 0, 20'hFFFFF, "R9 slot 2 kept");
      look(32'h0CCCC001, 1'b1, 1'b0, 0, 20'h0DDDD, "R9 second new page hit");

      // R10: flush empties, and a same-cycle refill is discarded
      do_flush();
      look(32'h0AAAA777, 1'b0, 1'b1, 1, 20'h0, "R10 flushed page misses");
      look(32'h00100010, 1'b0, 1'b1, 1, 20'h0, "R10 flushed page misses");
      fill(20'h05555, 20'h06666, 1'b1, 1'b1, 1'b1, 1'b1);
      look(32'h05555000, 1'b0, 1'b0, 1, 20'h0, "R10 refill with flush discarded");

      // R8: after flush, eight new pages all land in free slots
      for (int i = 0; i < 8; i++) fill(20'h00300 + 20'(i), 20'h00400 + 20'(i), 1'b1, 1'b1, 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) look({20'h00300 + 20'(i), 12'hF0F}, 1'b1, 1'b1, 0, 20'h00400 + 20'(i), "R8 refill after flush");

      // R5: no outputs without a request even on a cached page
      idle(32'h00300F0F, "R5 idle on cached page");

      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule